// File: doc/BRIEF.md
# Five-Lane Noisy Pseudo-Random Word Generator

This block produces 32-bit pseudo-random words. Its state is held in five shift-register lanes. The lanes differ in length, in feedback polynomial and in feedback form: some use external XOR feedback and some use internal XOR feedback. Every clock, each lane advances by one step. A one-bit noise input is folded into the feedback of lane 0, so the sequence cannot be predicted from the seeds alone. The output word is formed by XOR-combining the lanes and then rotating the result by an amount that lane 1 supplies.

A host can load any lane with a seed at any time. It asks for words through a request/ready handshake and may read as many words in a row as it likes. Between two delivered words the lanes advance at least 32 times, so consecutive words never share a trivially related state.

Top module: `rng_top`

## Requirements
- R1: While `rst_n` is low, every lane holds the value 1, `req_ready` is 0 and `out_valid` is 0.
- R2: The lanes are numbered 0 to 4. Each lane steps once on every rising clock edge on which it is not being loaded.
  - Lane 0 is 31 bits with external feedback: it shifts left and its new bit 0 is s[30]^s[27].
  - Lane 1 is 29 bits with internal feedback: it shifts right, and when the bit shifted out is 1 it XORs in the mask 0x14000000.
  - Lane 2 is 23 bits with external feedback, shifting left with new bit s[22]^s[17].
  - Lane 3 is 19 bits with internal feedback, shifting right with mask 0x00072000.
  - Lane 4 is 17 bits with external feedback, shifting left with new bit s[16]^s[13].
- R3: `noise_in` is XORed into the new bit of lane 0 on every step. If a lane step would produce all zeros, the lane takes the value 1 instead. A different noise pattern from the same seeds yields a different word.
- R4: The scrambled word is the XOR of all five lanes, each zero-extended to 32 bits, rotated left by the value of lane 1 bits [4:0].
- R5: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. In the following cycle `out_valid` is 1 for exactly one cycle. `out_word` then carries the scrambled word of the lane state as it was just before that edge. `out_valid` is never 1 otherwise.
- R6: `req_ready` is 1 exactly when at least 32 rising edges have passed since the last reset, accepted request or valid seed write. A request made while `req_ready` is 0 is ignored.
- R7: When `seed_we` is 1 and `seed_idx` is 0 to 4, the selected lane loads the low bits of `seed_data` that fit its length and does not step on that edge, while the other lanes step. A seed write restarts the 32-edge wait. A `seed_idx` of 5 to 7 has no effect on the lanes or on `req_ready`.
- R8: A seed that would leave the selected lane all zeros loads the value 1 instead.
- R9: Words can be requested without limit. Each further request after the wait delivers a new word built from the advanced state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noise_in | input | 1 | External noise bit folded into lane 0 |
| seed_we | input | 1 | Seed write strobe |
| seed_idx | input | 3 | Lane selected by a seed write |
| seed_data | input | 32 | Seed value; low bits are used |
| req_valid | input | 1 | Host requests a word |
| req_ready | output | 1 | Generator can accept a request |
| out_valid | output | 1 | One-cycle pulse marking a delivered word |
| out_word | output | 32 | Delivered random word |

## Verification
The hardest case to reach from the ports is lane 0 collapsing to zero, because that only happens when the noise bit cancels the last set bit being shifted out. The stimulus seeds lane 0 with a zero value, which forces a one-hot state, and then drives noise patterns against it. It also drives constant-zero and constant-one noise from identical seeds, so the words must differ. A bench model tracks every lane edge by edge from the stated polynomials, which lets each delivered word be compared bit for bit. Seed writes to the three unused lane indices check that the pacing count and the lanes are both left untouched.

// File: rtl/rng_pkg.sv
package rng_pkg;
   localparam int NLANE      = 5;
   localparam int IDX_W      = 3;
   localparam int ROT_LANE   = 1;
   localparam int NOISE_LANE = 0;
   // lane lengths, feedback masks (bit k = tap on stage k) and form (1 = internal XOR)
   localparam int          LANE_LEN [NLANE] = '{31, 29, 23, 19, 17};
   localparam logic [31:0] LANE_TAP [NLANE] = '{32'h4800_0000, 32'h1400_0000,
                                                32'h0042_0000, 32'h0007_2000,
                                                32'h0001_2000};
   localparam bit          LANE_GAL [NLANE] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
endpackage

// File: rtl/rng_lfsr.sv
module rng_lfsr #(
   parameter int         W      = 17,
   parameter logic [W-1:0] TAPS = '1,
   parameter bit         GALOIS = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   input  logic         noise,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   generate
      if (W < 3) begin : g_bad_w
         $error("rng_lfsr: W must be at least 3");
      end
      if (GALOIS) begin : g_internal
         always_comb begin
            nxt = (q >> 1) ^ (q[0] ? TAPS : '0);
            nxt[W-1] = nxt[W-1] ^ noise;
         end
      end else begin : g_external
         always_comb nxt = {q[W-2:0], (^(q & TAPS)) ^ noise};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)           q <= W'(1);
      else if (load)        q <= (ld_val == '0) ? W'(1) : ld_val;
      else if (nxt == '0)   q <= W'(1);
      else                  q <= nxt;
   end
endmodule

// File: rtl/rng_scramble.sv
module rng_scramble #(
   parameter int NLANE    = 5,
   parameter int WORD_W   = 32,
   parameter int ROT_LANE = 1
) (
   input  logic [NLANE-1:0][WORD_W-1:0] lanes,
   output logic [WORD_W-1:0]            word
);
   localparam int RW = $clog2(WORD_W);
   logic [WORD_W-1:0]   mix;
   logic [2*WORD_W-1:0] dbl;
   logic [RW-1:0]       amt;

   generate
      if (ROT_LANE >= NLANE) begin : g_bad_rot
         $error("rng_scramble: ROT_LANE out of range");
      end
   endgenerate

   always_comb begin
      mix = '0;
      for (int i = 0; i < NLANE; i++) mix = mix ^ lanes[i];
      amt  = lanes[ROT_LANE][RW-1:0];
      dbl  = {mix, mix} << amt;
      word = dbl[2*WORD_W-1:WORD_W];
   end
endmodule

// File: rtl/rng_pace.sv
module rng_pace #(
   parameter int GAP    = 32,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              restart,
   input  logic [WORD_W-1:0] word_in,
   output logic              req_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word
);
   localparam int CW = $clog2(GAP + 1);
   logic [CW-1:0] cnt;
   logic          accept;

   generate
      if (GAP < 1) begin : g_bad_gap
         $error("rng_pace: GAP must be positive");
      end
   endgenerate

   assign req_ready = (cnt == CW'(GAP));
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         out_valid <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= accept;
         if (accept) out_word <= word_in;
         if (accept || restart)     cnt <= '0;
         else if (cnt != CW'(GAP))  cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rng_top.sv
module rng_top
   import rng_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int GAP    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              noise_in,
   input  logic              seed_we,
   input  logic [IDX_W-1:0]  seed_idx,
   input  logic [WORD_W-1:0] seed_data,
   input  logic              req_valid,
   output logic              req_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word
);
   logic [NLANE-1:0][WORD_W-1:0] lane_q;
   logic [WORD_W-1:0]            scr_word;
   logic                         seed_hit;

   generate
      if (GAP < WORD_W) begin : g_bad_gap
         $error("rng_top: GAP must cover a full word of steps");
      end
      if ((1 << IDX_W) < NLANE) begin : g_bad_idx
         $error("rng_top: IDX_W too narrow for NLANE");
      end
   endgenerate

   assign seed_hit = seed_we && (seed_idx < IDX_W'(NLANE));

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      localparam int W = LANE_LEN[g];
      logic [W-1:0] q;
      logic         ld;
      logic         nz;

      if (W >= WORD_W) begin : g_bad_len
         $error("rng_top: lane longer than output word");
      end
      if (g == NOISE_LANE) begin : g_noisy
         assign nz = noise_in;
      end else begin : g_quiet
         assign nz = 1'b0;
      end

      assign ld = seed_we && (seed_idx == IDX_W'(g));

      rng_lfsr #(
         .W      (W),
         .TAPS   (LANE_TAP[g][W-1:0]),
         .GALOIS (LANE_GAL[g])
      ) u_lfsr (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (ld),
         .ld_val (seed_data[W-1:0]),
         .noise  (nz),
         .q      (q)
      );

      assign lane_q[g] = {{(WORD_W-W){1'b0}}, q};
   end

   rng_scramble #(
      .NLANE    (NLANE),
      .WORD_W   (WORD_W),
      .ROT_LANE (ROT_LANE)
   ) u_scr (
      .lanes (lane_q),
      .word  (scr_word)
   );

   rng_pace #(
      .GAP    (GAP),
      .WORD_W (WORD_W)
   ) u_pace (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .restart   (seed_hit),
      .word_in   (scr_word),
      .req_ready (req_ready),
      .out_valid (out_valid),
      .out_word  (out_word)
   );
endmodule

// File: rtl/rng_top_chk.sv
module rng_top_chk
   import rng_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         req_valid,
   input logic                         req_ready,
   input logic                         out_valid,
   input logic                         seed_we,
   input logic [IDX_W-1:0]             seed_idx,
   input logic [NLANE-1:0][WORD_W-1:0] lanes
);
   // R5: an accepted request yields a word pulse next cycle
   a_r5_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> out_valid);

   // R5: no word pulse without an accepted request
   a_r5_valid_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(req_valid && req_ready));

   // R6: ready drops after an accept
   a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   // R6, R7: ready stays up with no request and no valid seed write
   a_r6_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid && !(seed_we && seed_idx < IDX_W'(NLANE))) |=> req_ready);

   // R3, R8: no lane is ever all zeros
   for (genvar i = 0; i < NLANE; i++) begin : g_nz
      a_r8_lane_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
         lanes[i] != '0);
   end
endmodule

bind rng_top rng_top_chk #(.WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .out_valid (out_valid),
   .seed_we   (seed_we),
   .seed_idx  (seed_idx),
   .lanes     (lane_q)
);

// File: tb/tb_rng_top.sv
`timescale 1ns/1ps
module tb_rng_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        noise_in;
   logic        seed_we;
   logic [2:0]  seed_idx;
   logic [31:0] seed_data;
   logic        req_valid;
   logic        req_ready;
   logic        out_valid;
   logic [31:0] out_word;

   int nchk = 0;
   int nfail = 0;

   always #2 clk = ~clk;

   rng_top dut (
      .clk(clk), .rst_n(rst_n), .noise_in(noise_in), .seed_we(seed_we),
      .seed_idx(seed_idx), .seed_data(seed_data), .req_valid(req_valid),
      .req_ready(req_ready), .out_valid(out_valid), .out_word(out_word)
   );

   localparam logic [31:0] MASK [5] = '{32'h7FFF_FFFF, 32'h1FFF_FFFF,
                                        32'h007F_FFFF, 32'h0007_FFFF, 32'h0001_FFFF};
   // rows: seeds for lanes 0..4, then noise pattern (bit k used on wait cycle k)
   localparam logic [31:0] VEC [4][6] = '{
      '{32'h1234_5678, 32'h0BAD_F00D, 32'h0055_AA33, 32'h0003_1337, 32'h0001_CAFE, 32'h0000_0000},
      '{32'h7FFF_FFFF, 32'h1FFF_FFFF, 32'h007F_FFFF, 32'h0007_FFFF, 32'h0001_FFFF, 32'hFFFF_FFFF},
      '{32'h0000_0001, 32'h0000_0002, 32'h0000_0004, 32'h0000_0008, 32'h0000_0010, 32'hA5A5_5A5A},
      '{32'h6C3B_19E2, 32'h1F00_00F1, 32'h0040_0001, 32'h0004_0000, 32'h0001_0000, 32'h0F0F_3C3C}
   };

   logic [31:0] m [5];
   int          mcnt;
   string       wtag;
   logic [31:0] last_word;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mstep(input int i, input logic [31:0] s, input logic nz);
      logic [31:0] r;
      case (i)
         0: r = {1'b0, s[29:0], s[30] ^ s[27] ^ nz};
         1: r = {4'b0, s[28:1]} ^ (s[0] ? 32'h1400_0000 : 32'h0);
         2: r = {9'b0, s[21:0], s[22] ^ s[17]};
         3: r = {14'b0, s[18:1]} ^ (s[0] ? 32'h0007_2000 : 32'h0);
         default: r = {15'b0, s[15:0], s[16] ^ s[13]};
      endcase
      if (r == 32'h0) r = 32'h1;
      return r;
   endfunction

   function automatic logic [31:0] mscr();
      logic [31:0] x;
      int          r;
      x = m[0] ^ m[1] ^ m[2] ^ m[3] ^ m[4];
      r = int'(m[1][4:0]);
      return (x << r) | (x >> (32 - r));
   endfunction

   // one clock with model update and output checks (R2, R4, R5, R6, R7)
   task automatic tick();
      logic [31:0] nm [5];
      bit          acc;
      bit          hit;
      logic [31:0] ew;
      acc = req_valid && (mcnt == 32);
      hit = seed_we && (seed_idx < 3'd5);
      ew  = mscr();
      for (int i = 0; i < 5; i++) begin
         if (seed_we && seed_idx == 3'(i)) begin
            nm[i] = seed_data & MASK[i];
            if (nm[i] == 32'h0) nm[i] = 32'h1;
         end else begin
            nm[i] = mstep(i, m[i], noise_in);
         end
      end
      @(posedge clk);
      @(negedge clk);
      m = nm;
      if (acc || hit) mcnt = 0;
      else if (mcnt < 32) mcnt++;
      chk(out_valid === acc, "R5 valid pulse", {31'b0, out_valid}, {31'b0, acc});
      if (acc) begin
         chk(out_word === ew, wtag, out_word, ew);
         last_word = out_word;
      end
      chk(req_ready === (mcnt == 32), "R6 ready timing", {31'b0, req_ready}, {31'b0, mcnt == 32});
   endtask

   task automatic seed(input logic [2:0] idx, input logic [31:0] d);
      seed_we = 1'b1; seed_idx = idx; seed_data = d;
      tick();
      seed_we = 1'b0; seed_data = '0; seed_idx = '0;
   endtask

   task automatic get_word();
      while (mcnt != 32) tick();
      req_valid = 1'b1;
      tick();
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      logic [31:0] w0, w1;
      rst_n = 1'b0; noise_in = 1'b0; seed_we = 1'b0; seed_idx = '0;
      seed_data = '0; req_valid = 1'b0; wtag = "R4 word";
      for (int i = 0; i < 5; i++) m[i] = 32'h1;
      mcnt = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(req_ready === 1'b0, "R1 ready in reset", {31'b0, req_ready}, 32'h0);
      chk(out_valid === 1'b0, "R1 valid in reset", {31'b0, out_valid}, 32'h0);
      rst_n = 1'b1;

      // R6: request held high is ignored until 32 edges have passed; R1/R2 word from reset state
      wtag = "R2 word from reset state";
      req_valid = 1'b1;
      for (int k = 0; k < 31; k++) tick();
      chk(req_ready === 1'b0, "R6 ready before 32 edges", {31'b0, req_ready}, 32'h0);
      tick();
      chk(req_ready === 1'b1, "R6 ready after 32 edges", {31'b0, req_ready}, 32'h1);
      tick();
      req_valid = 1'b0;

      // table of seeds and noise patterns (R2, R3, R4, R9)
      for (int v = 0; v < 4; v++) begin
         wtag = "R4 scrambled word";
         for (int i = 0; i < 5; i++) seed(3'(i), VEC[v][i]);
         for (int k = 0; k < 32; k++) begin
            noise_in = VEC[v][5][k];
            tick();
         end
         noise_in = 1'b0;
         get_word();
         w0 = last_word;
         wtag = "R9 following word";
         get_word();
         chk(last_word !== w0, "R9 successive words differ", last_word, w0);
      end

      // R7: seed write restarts the wait
      seed(3'd2, 32'h0012_3456);
      chk(req_ready === 1'b0, "R7 seed restarts wait", {31'b0, req_ready}, 32'h0);

      // R7: out-of-range indices change nothing
      wtag = "R7 unused index left lanes alone";
      while (mcnt != 32) tick();
      for (int j = 5; j < 8; j++) begin
         seed(3'(j), 32'hDEAD_BEEF);
         chk(req_ready === 1'b1, "R7 unused index keeps ready", {31'b0, req_ready}, 32'h1);
      end
      get_word();

      // R8: zero seeds forced to 1, with noise toggling against one-hot lane 0
      wtag = "R8 zero seed word";
      seed(3'd0, 32'h8000_0000);
      seed(3'd2, 32'h0000_0000);
      seed(3'd4, 32'hFFFE_0000);
      for (int k = 0; k < 32; k++) begin
         noise_in = k[0];
         tick();
      end
      noise_in = 1'b0;
      get_word();
      wtag = "R3 noise collapse";
      seed(3'd0, 32'h4000_0000);
      noise_in = 1'b1;
      tick();
      noise_in = 1'b0;
      get_word();

      // R3: noise changes the output from identical seeds
      wtag = "R3 quiet noise word";
      for (int i = 0; i < 5; i++) seed(3'(i), VEC[0][i]);
      noise_in = 1'b0;
      get_word();
      w0 = last_word;
      wtag = "R3 loud noise word";
      for (int i = 0; i < 5; i++) seed(3'(i), VEC[0][i]);
      noise_in = 1'b1;
      get_word();
      w1 = last_word;
      noise_in = 1'b0;
      chk(w0 !== w1, "R3 noise alters word", w1, w0);

      // R9: a long run of requests
      wtag = "R9 long run";
      for (int k = 0; k < 20; k++) get_word();

      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule